// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block produces the source and destination byte addresses for one programmed memory transfer that is shaped in three nested levels. The innermost level is an array of bytes. An array repeats to form a frame, and a frame repeats to form a block. Each side has its own array stride and frame stride, which are signed. A side can also be set to hold a fixed address, for a FIFO-like endpoint. A downstream bus master takes one address pair per cycle through a valid/ready handshake.

Software writes parameter sets into a small store through a word-wide write port. Slot 0 is the active set. A sync pulse starts one unit of work, and the programmed sync mode decides whether that unit is one array, one frame or the whole block. Sync pulses that arrive while a unit is running are kept in a saturating counter and are served in order. When the block ends, the block raises a one-cycle completion pulse. It then copies the linked slot into slot 0, so ping-pong, circular and continuous transfers run without software help. A link of all ones clears slot 0 to a null set instead.

Top module: `dma3d_seq`

## Requirements
- R1: Slot `cfgSet` takes `cfgData` on a clock edge with `cfgWe` high, by word `cfgWord`. Word 0 holds byte count [15:0] and array count [31:16]. Word 1 holds frame count [15:0], sync mode [17:16] (0 array, 1 frame, 2 or 3 block), source constant [18], destination constant [19], intermediate completion [20] and link [24 +: 2]. Word 2 is the source base. Word 3 is the destination base. Word 4 holds the source array stride [15:0] and the destination array stride [31:16]. Word 5 holds the source frame stride [15:0] and the destination frame stride [31:16]. Strides are two's complement.
- R2: In block mode, one sync pulse emits byteCnt*arrCnt*frmCnt pairs in nested order: byte innermost, then array, then frame.
- R3: For an incrementing side, each next byte of an array is the previous address plus 1. After the last byte of an array, the address becomes that array's start plus the array stride. After the last array of a frame, it becomes that frame's start plus the frame stride. The two sides use their own strides.
- R4: A side set to constant addressing presents its base address for every pair of the transfer.
- R5: In array mode, each sync pulse emits exactly byteCnt pairs. In frame mode, each sync pulse emits exactly byteCnt*arrCnt pairs.
- R6: `outValid` rises on the cycle after the clock edge that samples a sync pulse, when the block is idle. While `outValid` is high and `outReady` is low, the pair holds steady. The pair advances only on an accepted cycle.
- R7: `cpl` is high for exactly one cycle, the cycle after the last pair of the block is accepted. When intermediate completion is set, it also pulses the cycle after the last pair of each array-mode or frame-mode unit.
- R8: A sync pulse that arrives while a unit is in progress is counted and served later, up to 15 pending. Pulses beyond 15 are dropped.
- R9: At block end, slot 0 becomes a copy of the linked slot. A link of 3 (all ones) clears slot 0 to null. A set with any count of zero is null, and a sync pulse on a null set emits nothing.
- R10: After reset, `outValid` and `cpl` are low and every slot is null.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Parameter word write strobe |
| cfgSet | input | 2 | Slot index to write |
| cfgWord | input | 3 | Word index within the slot |
| cfgData | input | 32 | Word value |
| syncIn | input | 1 | Sync pulse, one per cycle held high |
| outValid | output | 1 | Address pair is valid |
| outReady | input | 1 | Consumer accepts the pair |
| outSrc | output | 32 | Source byte address |
| outDst | output | 32 | Destination byte address |
| cpl | output | 1 | Completion pulse |

## Verification
The first pair is due one cycle after the edge that samples a sync pulse. Each later pair is due on the cycle after each accepted pair. `cpl` comes one cycle after the last accepted pair of a unit or block. The bench drives inputs on the falling edge. A monitor records each accepted pair and each `cpl` shortly after that edge. Each `cpl` is tagged with the number of pairs accepted so far, so completion timing is checked against exact byte positions rather than wall-clock cycles. Whole address sequences are compared in order against a nested-loop model built from the programmed counts and strides. The link test and the pending-count test look at how many pairs each later sync pulse produces.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  parameter int ADDR_W = 32;
  parameter int CNT_W  = 16;
  parameter int IDX_W  = 16;
  parameter int NSETS  = 4;
  parameter int LINK_W = $clog2(NSETS);
  parameter int PEND_W = 4;

  typedef enum logic [1:0] {
    SYNC_ARRAY = 2'd0,
    SYNC_FRAME = 2'd1,
    SYNC_BLOCK = 2'd2,
    SYNC_BLK2  = 2'd3
  } syncE;

  typedef struct packed {
    logic [CNT_W-1:0]        byteCnt;
    logic [CNT_W-1:0]        arrCnt;
    logic [CNT_W-1:0]        frmCnt;
    logic [ADDR_W-1:0]       srcBase;
    logic [ADDR_W-1:0]       dstBase;
    logic signed [IDX_W-1:0] srcArrIdx;
    logic signed [IDX_W-1:0] dstArrIdx;
    logic signed [IDX_W-1:0] srcFrmIdx;
    logic signed [IDX_W-1:0] dstFrmIdx;
    logic                    srcConst;
    logic                    dstConst;
    logic                    interm;
    syncE                    sync;
    logic [LINK_W-1:0]       link;
  } parSetT;

  // control -> datapath
  typedef struct packed {
    logic start;   // begin a sync unit (loads counters if block not begun)
    logic step;    // current pair accepted
    logic finish;  // last pair of the block accepted
  } strobeT;

  // datapath -> control
  typedef struct packed {
    logic setValid;
    logic lastByte;
    logic lastArr;
    logic lastFrm;
    logic interm;
    syncE sync;
  } statT;

  function automatic parSetT nullSet();
    parSetT p;
    p = '0;
    p.link = '1;
    return p;
  endfunction
endpackage

// File: rtl/dma3d_ctrl.sv
module dma3d_ctrl
  import dma3d_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   syncIn,
  input  logic   outReady,
  input  statT   stat,
  output strobeT strb,
  output logic   outValid,
  output logic   cpl
);
  localparam int PEND_MAX = (1 << PEND_W) - 1;

  typedef enum logic {ST_IDLE, ST_RUN} stE;

  stE              state, stateNext;
  logic [PEND_W-1:0] pend, pendNext;
  logic [PEND_W:0]   avail, pendRaw;
  logic fire, arrEnd, frmEnd, blkEnd, unitEnd, haveReq;

  always_comb begin
    fire    = (state == ST_RUN) && outReady;
    arrEnd  = fire && stat.lastByte;
    frmEnd  = arrEnd && stat.lastArr;
    blkEnd  = frmEnd && stat.lastFrm;
    case (stat.sync)
      SYNC_ARRAY: unitEnd = arrEnd;
      SYNC_FRAME: unitEnd = frmEnd;
      default:    unitEnd = blkEnd;
    endcase
    avail   = {1'b0, pend} + (PEND_W+1)'(syncIn);
    haveReq = (avail != '0);

    strb.step   = fire;
    strb.finish = blkEnd;
    strb.start  = ((state == ST_IDLE) && stat.setValid && haveReq) ||
                  (unitEnd && !blkEnd && haveReq);

    pendRaw  = avail - (PEND_W+1)'(strb.start);
    pendNext = (pendRaw > (PEND_W+1)'(PEND_MAX)) ? PEND_W'(PEND_MAX)
                                                 : pendRaw[PEND_W-1:0];
    if ((state == ST_IDLE) && !stat.setValid) pendNext = '0;

    stateNext = state;
    if (state == ST_IDLE) begin
      if (strb.start) stateNext = ST_RUN;
    end else if (unitEnd && !strb.start) begin
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pend  <= '0;
      cpl   <= 1'b0;
    end else begin
      state <= stateNext;
      pend  <= pendNext;
      cpl   <= blkEnd || (unitEnd && stat.interm);
    end
  end

  assign outValid = (state == ST_RUN);
endmodule

// File: rtl/dma3d_dpath.sv
module dma3d_dpath
  import dma3d_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [LINK_W-1:0] cfgSet,
  input  logic [2:0]        cfgWord,
  input  logic [31:0]       cfgData,
  input  strobeT            strb,
  output statT              stat,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr
);
  parSetT sets [NSETS];
  parSetT act;
  logic [CNT_W-1:0] aRem, bRem, cRem;
  logic begun;
  logic loadNow;
  logic unusedCfg;

  assign act       = sets[0];
  assign loadNow   = strb.start && !begun;
  assign unusedCfg = &{1'b0, cfgData[23:21], cfgData[31:24+LINK_W]};

  // parameter store; slot 0 is the active set
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSETS; i++) sets[i] <= nullSet();
    end else begin
      if (strb.finish)
        sets[0] <= (act.link == '1) ? nullSet() : sets[act.link];
      if (cfgWe) begin
        case (cfgWord)
          3'd0: begin
            sets[cfgSet].byteCnt <= cfgData[15:0];
            sets[cfgSet].arrCnt  <= cfgData[31:16];
          end
          3'd1: begin
            sets[cfgSet].frmCnt   <= cfgData[15:0];
            sets[cfgSet].sync     <= syncE'(cfgData[17:16]);
            sets[cfgSet].srcConst <= cfgData[18];
            sets[cfgSet].dstConst <= cfgData[19];
            sets[cfgSet].interm   <= cfgData[20];
            sets[cfgSet].link     <= cfgData[24 +: LINK_W];
          end
          3'd2: sets[cfgSet].srcBase <= cfgData;
          3'd3: sets[cfgSet].dstBase <= cfgData;
          3'd4: begin
            sets[cfgSet].srcArrIdx <= cfgData[15:0];
            sets[cfgSet].dstArrIdx <= cfgData[31:16];
          end
          3'd5: begin
            sets[cfgSet].srcFrmIdx <= cfgData[15:0];
            sets[cfgSet].dstFrmIdx <= cfgData[31:16];
          end
          default: ;
        endcase
      end
    end
  end

  // three-level counters
  always_ff @(posedge clk) begin
    if (rst) begin
      aRem <= '0; bRem <= '0; cRem <= '0; begun <= 1'b0;
    end else if (loadNow) begin
      aRem <= act.byteCnt; bRem <= act.arrCnt; cRem <= act.frmCnt;
      begun <= 1'b1;
    end else if (strb.step) begin
      if (strb.finish) begun <= 1'b0;
      if (!stat.lastByte) begin
        aRem <= aRem - 1'b1;
      end else begin
        aRem <= act.byteCnt;
        if (!stat.lastArr) begin
          bRem <= bRem - 1'b1;
        end else begin
          bRem <= act.arrCnt;
          cRem <= cRem - 1'b1;
        end
      end
    end
  end

  // per-side address walkers
  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [ADDR_W-1:0] addr, arrS, frmS, base, bStep, cStep;
    logic signed [IDX_W-1:0] bIdx, cIdx;
    logic cnst;

    assign base  = (s == 0) ? act.srcBase   : act.dstBase;
    assign bIdx  = (s == 0) ? act.srcArrIdx : act.dstArrIdx;
    assign cIdx  = (s == 0) ? act.srcFrmIdx : act.dstFrmIdx;
    assign cnst  = (s == 0) ? act.srcConst  : act.dstConst;
    assign bStep = arrS + {{(ADDR_W-IDX_W){bIdx[IDX_W-1]}}, bIdx};
    assign cStep = frmS + {{(ADDR_W-IDX_W){cIdx[IDX_W-1]}}, cIdx};

    always_ff @(posedge clk) begin
      if (rst) begin
        addr <= '0; arrS <= '0; frmS <= '0;
      end else if (loadNow) begin
        addr <= base; arrS <= base; frmS <= base;
      end else if (strb.step && !cnst) begin
        if (!stat.lastByte) begin
          addr <= addr + 1'b1;
        end else if (!stat.lastArr) begin
          addr <= bStep; arrS <= bStep;
        end else begin
          addr <= cStep; arrS <= cStep; frmS <= cStep;
        end
      end
    end
  end

  assign srcAddr = g_side[0].addr;
  assign dstAddr = g_side[1].addr;

  always_comb begin
    stat.setValid = (act.byteCnt != '0) && (act.arrCnt != '0) && (act.frmCnt != '0);
    stat.lastByte = (aRem == CNT_W'(1));
    stat.lastArr  = (bRem == CNT_W'(1));
    stat.lastFrm  = (cRem == CNT_W'(1));
    stat.interm   = act.interm;
    stat.sync     = act.sync;
  end
endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
  import dma3d_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [LINK_W-1:0] cfgSet,
  input  logic [2:0]        cfgWord,
  input  logic [31:0]       cfgData,
  input  logic              syncIn,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outSrc,
  output logic [ADDR_W-1:0] outDst,
  output logic              cpl
);
  strobeT strb;
  statT   stat;

  dma3d_ctrl u_ctrl (
    .clk(clk), .rst(rst), .syncIn(syncIn), .outReady(outReady),
    .stat(stat), .strb(strb), .outValid(outValid), .cpl(cpl)
  );

  dma3d_dpath u_dpath (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSet(cfgSet), .cfgWord(cfgWord),
    .cfgData(cfgData), .strb(strb), .stat(stat),
    .srcAddr(outSrc), .dstAddr(outDst)
  );
endmodule

// File: rtl/dma3d_seq_chk.sv
module dma3d_seq_chk
  import dma3d_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outSrc,
  input logic [ADDR_W-1:0] outDst,
  input logic              cpl,
  input logic              lastByte,
  input logic              setValid
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outSrc) && $stable(outDst))); // R6

  AST_CPL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    cpl |-> $past(outValid && outReady)); // R7

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && !lastByte) |=>
      ((outSrc == $past(outSrc) + 1'b1) || (outSrc == $past(outSrc)))); // R3

  AST_NULL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !setValid) |=> !outValid); // R9
endmodule

bind dma3d_seq dma3d_seq_chk u_chk (
  .clk(clk), .rst(rst), .outValid(outValid), .outReady(outReady),
  .outSrc(outSrc), .outDst(outDst), .cpl(cpl),
  .lastByte(stat.lastByte), .setValid(stat.setValid)
);

// File: tb/dma3d_seq_tb.sv
module dma3d_seq_tb;
  import dma3d_pkg::*;

  logic clk, rst, cfgWe, syncIn, outValid, outReady, cpl;
  logic [LINK_W-1:0] cfgSet;
  logic [2:0] cfgWord;
  logic [31:0] cfgData, outSrc, outDst;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] capS [0:255], capD [0:255], expS [0:255], expD [0:255];
  int capN = 0, cplN = 0, expN = 0;
  int cplIdx [0:15];

  dma3d_seq u_dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSet(cfgSet), .cfgWord(cfgWord),
    .cfgData(cfgData), .syncIn(syncIn), .outValid(outValid), .outReady(outReady),
    .outSrc(outSrc), .outDst(outDst), .cpl(cpl)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // monitor: just after the falling edge, record what the next rising edge accepts
  always begin
    @(negedge clk);
    #1;
    if (!rst) begin
      if (outValid && outReady && capN < 256) begin
        capS[capN] = outSrc; capD[capN] = outDst; capN++;
      end
      if (cpl) begin
        if (cplN < 16) cplIdx[cplN] = capN;
        cplN++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint actV, input longint expV);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actV, expV);
    end
  endtask

  task automatic clearCap();
    capN = 0; cplN = 0; expN = 0;
  endtask

  task automatic genExp(input int a, input int b, input int c,
                        input logic [31:0] sb, input logic [31:0] db,
                        input int sB, input int dB, input int sC, input int dC,
                        input bit sK, input bit dK);
    for (int ci = 0; ci < c; ci++)
      for (int bi = 0; bi < b; bi++)
        for (int ai = 0; ai < a; ai++) begin
          expS[expN] = sK ? sb : sb + 32'(ci*sC + bi*sB + ai);
          expD[expN] = dK ? db : db + 32'(ci*dC + bi*dB + ai);
          expN++;
        end
  endtask

  task automatic chkSeq(input string req);
    check(capN == expN, req, "pair count", capN, expN);
    for (int i = 0; i < expN && i < capN; i++) begin
      check(capS[i] == expS[i], req, $sformatf("src[%0d]", i), capS[i], expS[i]);
      check(capD[i] == expD[i], req, $sformatf("dst[%0d]", i), capD[i], expD[i]);
    end
  endtask

  task automatic wr(input int set, input int w, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1; cfgSet = LINK_W'(set); cfgWord = 3'(w); cfgData = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic progSet(input int set, input int a, input int b, input int c,
                         input logic [31:0] sb, input logic [31:0] db,
                         input int sB, input int dB, input int sC, input int dC,
                         input int sync, input bit sK, input bit dK,
                         input bit im, input int link);
    wr(set, 0, {16'(b), 16'(a)});
    wr(set, 1, {8'(link), 3'b0, im, dK, sK, 2'(sync), 16'(c)});
    wr(set, 2, sb);
    wr(set, 3, db);
    wr(set, 4, {16'(dB), 16'(sB)});
    wr(set, 5, {16'(dC), 16'(sC)});
  endtask

  task automatic trig();
    @(negedge clk); syncIn = 1;
    @(negedge clk); syncIn = 0;
  endtask

  task automatic waitIdle();
    int q = 0;
    for (int k = 0; k < 3000 && q < 4; k++) begin
      @(negedge clk);
      q = outValid ? 0 : q + 1;
    end
  endtask

  task automatic t_reset();
    check(outValid == 0, "R10", "outValid after reset", outValid, 0);
    check(cpl == 0, "R10", "cpl after reset", cpl, 0);
    clearCap();
    trig();
    waitIdle();
    check(capN == 0, "R9", "pairs from null set after reset (R10)", capN, 0);
  endtask

  task automatic t_block();
    clearCap();
    progSet(0, 3, 2, 2, 32'h1000, 32'h8000, 16, 8, 64, -32, 2, 0, 0, 0, 3);
    genExp(3, 2, 2, 32'h1000, 32'h8000, 16, 8, 64, -32, 0, 0);
    outReady = 1;
    trig();
    check(outValid == 1, "R6", "valid one cycle after sync", outValid, 1);
    check(outSrc == 32'h1000, "R1", "first src from base word", outSrc, 32'h1000);
    waitIdle();
    chkSeq("R2 R3");
    check(cplN == 1, "R7", "block cpl count", cplN, 1);
    check(cplIdx[0] == 12, "R7", "cpl after last pair", cplIdx[0], 12);
    trig();
    waitIdle();
    check(capN == 12, "R9", "no pairs after unlinked completion", capN, 12);
  endtask

  task automatic t_array();
    clearCap();
    progSet(0, 4, 3, 1, 32'h4000, 32'hA000, 32, 0, 0, 0, 0, 0, 1, 0, 3);
    genExp(4, 3, 1, 32'h4000, 32'hA000, 32, 0, 0, 0, 0, 1);
    trig(); waitIdle();
    check(capN == 4, "R5", "array mode first unit", capN, 4);
    check(cplN == 0, "R7", "no cpl mid block", cplN, 0);
    trig(); waitIdle();
    check(capN == 8, "R5", "array mode second unit", capN, 8);
    trig(); waitIdle();
    chkSeq("R4");
    check(cplN == 1 && cplIdx[0] == 12, "R7", "cpl only at block end", cplN, 1);
  endtask

  task automatic t_frame();
    clearCap();
    progSet(0, 2, 2, 2, 32'h5000, 32'hB000, 8, -4, 256, 100, 1, 1, 0, 1, 3);
    genExp(2, 2, 2, 32'h5000, 32'hB000, 8, -4, 256, 100, 1, 0);
    trig(); waitIdle();
    check(capN == 4, "R5", "frame mode unit", capN, 4);
    check(cplN == 1 && cplIdx[0] == 4, "R7", "intermediate cpl", cplIdx[0], 4);
    trig(); waitIdle();
    chkSeq("R3 R4");
    check(cplN == 2 && cplIdx[1] == 8, "R7", "final cpl", cplN, 2);
  endtask

  task automatic t_stall();
    clearCap();
    progSet(0, 2, 2, 1, 32'h6000, 32'hC000, 16, 16, 0, 0, 2, 0, 0, 0, 3);
    genExp(2, 2, 1, 32'h6000, 32'hC000, 16, 16, 0, 0, 0, 0);
    outReady = 0;
    trig();
    repeat (5) @(negedge clk);
    check(capN == 0 && outValid == 1, "R6", "no accept while not ready", capN, 0);
    check(outSrc == 32'h6000, "R6", "held first src", outSrc, 32'h6000);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      outReady = (k % 3) != 0;
    end
    outReady = 1;
    waitIdle();
    chkSeq("R6");
  endtask

  task automatic t_pend();
    clearCap();
    progSet(0, 2, 17, 1, 32'h7000, 32'hD000, 4, 4, 0, 0, 0, 0, 0, 0, 3);
    outReady = 0;
    trig();
    @(negedge clk); syncIn = 1;
    repeat (20) @(negedge clk);
    syncIn = 0;
    outReady = 1;
    waitIdle();
    check(capN == 32, "R8", "pending saturates at 15", capN, 32);
    check(cplN == 0, "R8", "no cpl before last array", cplN, 0);
    trig(); waitIdle();
    genExp(2, 17, 1, 32'h7000, 32'hD000, 4, 4, 0, 0, 0, 0);
    chkSeq("R8");
    check(cplN == 1, "R8", "cpl after final array", cplN, 1);
  endtask

  task automatic t_link();
    clearCap();
    progSet(1, 2, 1, 2, 32'h2000, 32'h3000, 0, 0, 16, 32, 2, 0, 0, 0, 3);
    progSet(0, 3, 1, 1, 32'h0100, 32'h0200, 0, 0, 0, 0, 2, 0, 0, 0, 1);
    genExp(3, 1, 1, 32'h0100, 32'h0200, 0, 0, 0, 0, 0, 0);
    genExp(2, 1, 2, 32'h2000, 32'h3000, 0, 0, 16, 32, 0, 0);
    trig(); waitIdle();
    check(capN == 3, "R9", "first set pairs", capN, 3);
    trig(); waitIdle();
    chkSeq("R9");
    check(cplN == 2, "R9", "cpl per linked block", cplN, 2);
    trig(); waitIdle();
    check(capN == 7, "R9", "null after unlinked set", capN, 7);
  endtask

  initial begin
    rst = 1; cfgWe = 0; cfgSet = '0; cfgWord = '0; cfgData = '0;
    syncIn = 0; outReady = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_block();
    t_array();
    t_frame();
    t_stall();
    t_pend();
    t_link();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule